// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing front end of a three-channel interval timer. A host reaches it over an 8-bit data bus with a 2-bit port address and separate read and write strobes. Ports 0, 1 and 2 reach the count registers of channels 0, 1 and 2. Port 3 takes control words. The block decodes each control word and keeps, for each channel, a byte-access format, a mode number and a BCD flag. It assembles the initial count from host bytes and gives the channel a one-cycle load strobe with the 16-bit value.

For reads, the block returns bytes of each channel's live count. The count comes in from the counting logic, which sits outside this block. A latch command freezes a snapshot of one channel's count. The host can then read the snapshot in byte steps while the counter keeps running. The snapshot stays frozen until the host has read it out in full in that channel's access format.

Top module: `tmr_host_if`

## Requirements
- R1: After reset, every channel uses LSB-only access, mode 0 and binary counting, with no snapshot held and no byte sequence in progress. `rdata`, `load_stb` and `cfg_stb` are all zero.
- R2: Ports 0 to 2 address channels 0 to 2, and port 3 takes control words. A read of port 3 returns 0x00.
- R3: In a control word, bits 7:6 select the channel (00, 01, 10 for channels 0, 1, 2). Bits 5:4 give the access format: 00 latch, 01 LSB only, 10 MSB only, 11 LSB then MSB. Bits 3:1 give the mode, and bit 0 set means BCD. A word whose access field is not 00 updates only the selected channel's mode, BCD flag and access format. It restarts that channel's byte sequences, drops any snapshot it holds, and pulses that channel's `cfg_stb` bit in the next cycle.
- R4: A control word with bits 7:6 equal to 11 changes no state and raises no strobe.
- R5: In LSB-only format, a data write pulses `load_stb` in the next cycle with the value {0x00, byte}. In MSB-only format the value is {byte, 0x00}.
- R6: In LSB-then-MSB format, the first data write only stores the low byte and gives no strobe. The second write pulses `load_stb` in the next cycle with {second byte, first byte}.
- R7: Read data shows on `rdata` one cycle after the read strobe and holds until the next read. LSB-only format returns bits 7:0 and MSB-only returns bits 15:8. LSB-then-MSB format alternates between bits 7:0 and bits 15:8, starting with bits 7:0.
- R8: A latch command (access field 00) captures the selected channel's count at that clock edge and restarts its read sequence. Reads then return this snapshot while the count input keeps changing.
- R9: The snapshot stays in place until it has been read out in full: one read in the 8-bit formats, or both bytes in LSB-then-MSB format. Reads after that return the live count.
- R10: A latch command that arrives while a snapshot is still held is ignored, and the first snapshot is kept.
- R11: A latch command does not change the channel's mode, BCD flag or access format, and it raises no `cfg_stb`.
- R12: When the read and write strobes are both high in one cycle, the write is carried out, the read is dropped and `rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Port address: 0 to 2 select a channel, 3 is the control port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| cnt_in | input | 48 | Live counts from the counters, 16 bits per channel, channel 0 in the low bits |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | Initial count per channel, valid while its `load_stb` bit is high |
| cfg_stb | output | 3 | One-cycle pulse per channel after a control word that sets up that channel |
| mode_out | output | 9 | Stored mode per channel, 3 bits each |
| bcd_out | output | 3 | Stored BCD flag per channel |

## Verification
Two actions can meet at one clock edge. The first is a read strobe arriving together with a write strobe (R12). The second is the latch capture arriving on the same edge where the external count changes (R8). The bench drives both strobes high in one cycle and expects the data write's load value to appear while `rdata` keeps its earlier byte. The count input moves on every clock edge, so each latch command hits a moving value. A behavioural model tracks which count value the capture edge sees, and each snapshot byte read back is compared with that value, taken by the bench at the moment the latch command went out.

// File: rtl/tmr_if_pkg.sv
package tmr_if_pkg;

  // Access format field of the control word
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  // Control word layout, bit 7 down to bit 0
  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_word_t;

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_if_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic          ctl_wr,
  input  logic [DW-1:0] wdata,
  output logic [NCH-1:0] cfg_we,
  output logic [NCH-1:0] latch_we,
  output acc_e          f_acc,
  output logic [2:0]    f_mode,
  output logic          f_bcd
);
  ctl_word_t cw;

  assign cw     = ctl_word_t'(wdata[7:0]);
  assign f_acc  = cw.acc;
  assign f_mode = cw.mode;
  assign f_bcd  = cw.bcd;

  // Select value 11 matches no channel, so such a word does nothing
  for (genvar g = 0; g < NCH; g++) begin : g_sel
    logic hit;
    assign hit         = ctl_wr && (cw.sel == 2'(g));
    assign cfg_we[g]   = hit && (cw.acc != ACC_LATCH);
    assign latch_we[g] = hit && (cw.acc == ACC_LATCH);
  end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_if_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          latch_we,
  input  acc_e          f_acc,
  input  logic [2:0]    f_mode,
  input  logic          f_bcd,
  input  logic          dat_we,
  input  logic          dat_re,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt_val,
  output logic [DW-1:0] rd_byte,
  output logic          load_stb,
  output logic [CW-1:0] load_val,
  output logic          cfg_stb,
  output logic [2:0]    mode,
  output logic          bcd
);
  acc_e          acc;
  logic          wptr;
  logic          rptr;
  logic          held;
  logic [DW-1:0] lo_byte;
  logic [CW-1:0] snap;
  logic [CW-1:0] src;

  // Byte that a read in this cycle returns
  assign src = held ? snap : cnt_val;

  always_comb begin
    unique case (acc)
      ACC_HI:   rd_byte = src[CW-1:DW];
      ACC_WORD: rd_byte = rptr ? src[CW-1:DW] : src[DW-1:0];
      default:  rd_byte = src[DW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= ACC_LO;
      mode     <= '0;
      bcd      <= 1'b0;
      wptr     <= 1'b0;
      rptr     <= 1'b0;
      held     <= 1'b0;
      lo_byte  <= '0;
      snap     <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
      cfg_stb  <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      cfg_stb  <= 1'b0;

      if (cfg_we) begin
        acc     <= f_acc;
        mode    <= f_mode;
        bcd     <= f_bcd;
        wptr    <= 1'b0;
        rptr    <= 1'b0;
        held    <= 1'b0;
        cfg_stb <= 1'b1;
      end else if (latch_we && !held) begin
        snap <= cnt_val;
        held <= 1'b1;
        rptr <= 1'b0;
      end

      if (dat_we) begin
        unique case (acc)
          ACC_HI: begin
            load_val <= {wdata, {DW{1'b0}}};
            load_stb <= 1'b1;
          end
          ACC_WORD: begin
            if (!wptr) begin
              lo_byte <= wdata;
              wptr    <= 1'b1;
            end else begin
              load_val <= {wdata, lo_byte};
              load_stb <= 1'b1;
              wptr     <= 1'b0;
            end
          end
          default: begin
            load_val <= {{DW{1'b0}}, wdata};
            load_stb <= 1'b1;
          end
        endcase
      end

      if (dat_re) begin
        if (acc == ACC_WORD) begin
          rptr <= !rptr;
          if (rptr) held <= 1'b0;
        end else begin
          held <= 1'b0;
        end
      end
    end
  end

  // R5: a single-byte load fills the other byte with zero
  p_lo_load_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (dat_we && acc == ACC_LO) |=> (load_stb && load_val[CW-1:DW] == '0));

  // R6: the first byte of a 16-bit load gives no strobe
  p_word_first_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (dat_we && acc == ACC_WORD && !wptr) |=> !load_stb);

  // R9: the snapshot stays held while nothing reads it out or sets up the channel
  p_held_until_read_r9: assert property (@(posedge clk) disable iff (rst)
    (held && !dat_re && !cfg_we) |=> held);

  // R10: a latch command while a snapshot is held leaves it alone
  p_relatch_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (latch_we && held) |=> $stable(snap));

  // R11: a latch command leaves the setup alone
  p_latch_keeps_cfg_r11: assert property (@(posedge clk) disable iff (rst)
    latch_we |=> ($stable(acc) && $stable(mode) && $stable(bcd) && !cfg_stb));

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_if_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8,
  parameter int AW  = $clog2(NCH + 1),
  localparam int CW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NCH*CW-1:0] cnt_in,
  output logic [NCH-1:0]   load_stb,
  output logic [NCH*CW-1:0] load_val,
  output logic [NCH-1:0]   cfg_stb,
  output logic [NCH*3-1:0] mode_out,
  output logic [NCH-1:0]   bcd_out
);
  localparam logic [AW-1:0] CTL_ADDR = AW'(NCH);

  logic           ctl_wr;
  logic           rd_ok;
  logic [NCH-1:0] cfg_we;
  logic [NCH-1:0] latch_we;
  acc_e           f_acc;
  logic [2:0]     f_mode;
  logic           f_bcd;
  logic [DW-1:0]  rd_byte [NCH];
  logic [DW-1:0]  rd_sel;

  assign ctl_wr = wr_en && (addr == CTL_ADDR);
  assign rd_ok  = rd_en && !wr_en;

  tmr_ctl_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .ctl_wr   (ctl_wr),
    .wdata    (wdata),
    .cfg_we   (cfg_we),
    .latch_we (latch_we),
    .f_acc    (f_acc),
    .f_mode   (f_mode),
    .f_bcd    (f_bcd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = (addr == AW'(g));

    tmr_chan_port #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we[g]),
      .latch_we (latch_we[g]),
      .f_acc    (f_acc),
      .f_mode   (f_mode),
      .f_bcd    (f_bcd),
      .dat_we   (wr_en && hit),
      .dat_re   (rd_ok && hit),
      .wdata    (wdata),
      .cnt_val  (cnt_in[g*CW +: CW]),
      .rd_byte  (rd_byte[g]),
      .load_stb (load_stb[g]),
      .load_val (load_val[g*CW +: CW]),
      .cfg_stb  (cfg_stb[g]),
      .mode     (mode_out[g*3 +: 3]),
      .bcd      (bcd_out[g])
    );
  end

  // The control port reads as zero because no channel matches its address
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) rd_sel = rd_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_ok) begin
      rdata <= rd_sel;
    end
  end

  // R2: the control port reads back as zero
  p_ctl_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == CTL_ADDR) |=> (rdata == '0));

  // R4: channel select 11 is dropped
  p_bad_sel_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wdata[7:6] == 2'b11) |=> (cfg_stb == '0 && load_stb == '0));

  // R12: a read that collides with a write is dropped
  p_clash_read_dropped_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(rdata));

endmodule

// File: tb/tmr_host_if_test.sv
module tmr_host_if_test;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] cnt_in;
  logic [2:0]  load_stb;
  logic [47:0] load_val;
  logic [2:0]  cfg_stb;
  logic [8:0]  mode_out;
  logic [2:0]  bcd_out;

  logic [15:0] cnt [3];
  int total = 0;
  int bad = 0;

  always #(PER/2) clk = !clk;

  tmr_host_if uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt_in(cnt_in), .load_stb(load_stb),
    .load_val(load_val), .cfg_stb(cfg_stb), .mode_out(mode_out), .bcd_out(bcd_out)
  );

  // Free-running counts, each channel stepping down by a different amount
  always @(posedge clk) begin
    if (rst) begin
      cnt[0] <= 16'hF0F0; cnt[1] <= 16'h8421; cnt[2] <= 16'h3C5A;
    end else begin
      for (int i = 0; i < 3; i++) cnt[i] <= cnt[i] - 16'(i + 1);
    end
  end
  always_comb cnt_in = {cnt[2], cnt[1], cnt[0]};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [1:0]  m_acc [3];
  logic [2:0]  m_mode [3];
  logic        m_bcd [3], m_wptr [3], m_rptr [3], m_held [3];
  logic [7:0]  m_lo [3];
  logic [15:0] m_snap [3], e_val [3];
  logic [2:0]  e_ld, e_cfg;
  logic [7:0]  e_rd;

  always @(posedge clk) begin
    logic [15:0] s;
    int c;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_acc[i] = 2'd1; m_mode[i] = 0; m_bcd[i] = 0; m_wptr[i] = 0;
        m_rptr[i] = 0; m_held[i] = 0; m_lo[i] = 0; m_snap[i] = 0; e_val[i] = 0;
      end
      e_ld = 0; e_cfg = 0; e_rd = 0;
    end else begin
      e_ld = 0; e_cfg = 0;
      if (wr_en) begin
        if (addr == 2'd3) begin
          c = int'(wdata[7:6]);
          if (c < 3) begin
            if (wdata[5:4] == 2'd0) begin
              if (!m_held[c]) begin
                m_snap[c] = cnt[c]; m_held[c] = 1; m_rptr[c] = 0;
              end
            end else begin
              m_acc[c] = wdata[5:4]; m_mode[c] = wdata[3:1]; m_bcd[c] = wdata[0];
              m_wptr[c] = 0; m_rptr[c] = 0; m_held[c] = 0; e_cfg[c] = 1;
            end
          end
        end else begin
          c = int'(addr);
          if (m_acc[c] == 2'd2) begin
            e_val[c] = {wdata, 8'h00}; e_ld[c] = 1;
          end else if (m_acc[c] == 2'd3) begin
            if (!m_wptr[c]) begin
              m_lo[c] = wdata; m_wptr[c] = 1;
            end else begin
              e_val[c] = {wdata, m_lo[c]}; e_ld[c] = 1; m_wptr[c] = 0;
            end
          end else begin
            e_val[c] = {8'h00, wdata}; e_ld[c] = 1;
          end
        end
      end else if (rd_en) begin
        if (addr == 2'd3) e_rd = 0;
        else begin
          c = int'(addr);
          s = m_held[c] ? m_snap[c] : cnt[c];
          if (m_acc[c] == 2'd2) begin
            e_rd = s[15:8]; m_held[c] = 0;
          end else if (m_acc[c] == 2'd3) begin
            e_rd = m_rptr[c] ? s[15:8] : s[7:0];
            if (m_rptr[c]) m_held[c] = 0;
            m_rptr[c] = !m_rptr[c];
          end else begin
            e_rd = s[7:0]; m_held[c] = 0;
          end
        end
      end
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R7 rdata", 32'(rdata), 32'(e_rd));
      check("R5 load_stb", 32'(load_stb), 32'(e_ld));
      check("R3 cfg_stb", 32'(cfg_stb), 32'(e_cfg));
      for (int i = 0; i < 3; i++) begin
        check("R6 load_val", 32'(load_val[i*16 +: 16]), 32'(e_val[i]));
        check("R3 mode_out", 32'(mode_out[i*3 +: 3]), 32'(m_mode[i]));
        check("R3 bcd_out", 32'(bcd_out[i]), 32'(m_bcd[i]));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PER * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  b, b2, prev;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 mode_out", 32'(mode_out), 0);
    check("R1 bcd_out", 32'(bcd_out), 0);
    check("R1 rdata", 32'(rdata), 0);
    check("R1 load_stb", 32'(load_stb), 0);
    wr(2'd0, 8'h11);
    check("R1 reset access is LSB only", 32'(load_val[15:0]), 32'h0011);

    // R2 control port read
    rd(2'd3, b);
    check("R2 control port reads zero", 32'(b), 0);

    // R3 setup of channel 1: 16-bit, mode 3, BCD
    wr(2'd3, 8'h77);
    check("R3 cfg_stb", 32'(cfg_stb), 32'b010);
    check("R3 mode ch1", 32'(mode_out[5:3]), 3);
    check("R3 bcd ch1", 32'(bcd_out), 32'b010);
    check("R3 mode ch0 untouched", 32'(mode_out[2:0]), 0);

    // R6 two-byte load
    wr(2'd1, 8'h34);
    check("R6 no strobe after low byte", 32'(load_stb), 0);
    wr(2'd1, 8'h12);
    check("R6 strobe after high byte", 32'(load_stb), 32'b010);
    check("R6 assembled value", 32'(load_val[31:16]), 32'h1234);

    // R5 MSB-only load on channel 2, mode 2
    wr(2'd3, 8'hA4);
    wr(2'd2, 8'hAB);
    check("R5 MSB only value", 32'(load_val[47:32]), 32'hAB00);
    check("R5 MSB only strobe", 32'(load_stb), 32'b100);

    // R4 select 11 ignored
    wr(2'd3, 8'hF6);
    check("R4 no cfg_stb", 32'(cfg_stb), 0);
    check("R4 modes unchanged", 32'(mode_out), 32'({3'd2, 3'd3, 3'd0}));

    // R7 live reads
    v = cnt[2];
    rd(2'd2, b);
    check("R7 MSB only read", 32'(b), 32'(v[15:8]));
    v = cnt[1];
    rd(2'd1, b);
    check("R7 16-bit read low first", 32'(b), 32'(v[7:0]));
    v = cnt[1];
    rd(2'd1, b);
    check("R7 16-bit read high second", 32'(b), 32'(v[15:8]));

    // R8, R11 latch channel 1
    v = cnt[1];
    wr(2'd3, 8'h40);
    check("R11 no cfg_stb on latch", 32'(cfg_stb), 0);
    check("R11 mode kept", 32'(mode_out[5:3]), 3);
    check("R11 bcd kept", 32'(bcd_out[1]), 1);
    idle(4);
    // R10 second latch ignored
    wr(2'd3, 8'h40);
    idle(2);
    rd(2'd1, b);
    rd(2'd1, b2);
    check("R8 snapshot low", 32'(b), 32'(v[7:0]));
    check("R10 snapshot high kept", 32'(b2), 32'(v[15:8]));
    // R9 released after both bytes
    v = cnt[1];
    rd(2'd1, b);
    check("R9 live after full read", 32'(b), 32'(v[7:0]));

    // R9 single-byte format: channel 0, LSB only
    v = cnt[0];
    wr(2'd3, 8'h00);
    idle(3);
    rd(2'd0, b);
    check("R9 8-bit snapshot", 32'(b), 32'(v[7:0]));
    v = cnt[0];
    rd(2'd0, b);
    check("R9 8-bit live after one read", 32'(b), 32'(v[7:0]));

    // R3 setup drops a held snapshot
    wr(2'd3, 8'h80);
    idle(3);
    wr(2'd3, 8'hB0);
    v = cnt[2];
    rd(2'd2, b);
    check("R3 setup drops snapshot", 32'(b), 32'(v[7:0]));

    // R12 read and write together
    prev = rdata;
    addr = 2'd0; wdata = 8'h22; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R12 write performed", 32'(load_val[15:0]), 32'h0022);
    check("R12 rdata held", 32'(rdata), 32'(prev));

    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule